// File: doc/BRIEF.md
# Output Drive Trim Controller

This block is the digital half of a calibration loop for an output driver whose strength is chosen from 32 binary-weighted settings. An external comparator reports whether the driver should be made stronger or weaker. The block looks at that report once per evaluation period and moves an internal target code by a single step in the direction it asks for. The code stops at both ends of its range and does not wrap.

The driver itself must not change strength while it is driving the pads. The target code is therefore copied to the applied code only while the pads are in High-Z. When the pads go from driven to High-Z, whether through a write, a deselect or the output enable, the pending value is applied at once. An alternative build applies the value only on that transition.

After power-up a cycle counter runs. The block raises a settled flag on the first driven-to-High-Z transition that follows the end of that count. The flag stays set until reset.

Top module: `drv_trim_ctrl`

## Requirements
- R1: While reset is asserted and on its release, `drv_code` equals RESET_CODE (default 16) and `settled` is 0.
- R2: The target code is evaluated only on every EVAL_PERIOD-th rising clock edge after reset release (default 64: edges 64, 128, 192, ...). No change occurs between those edges.
- R3: At each evaluation the target moves by exactly one step. It goes up by one when `cmp_up` is 1 and down by one when `cmp_up` is 0.
- R4: The target saturates. An up step at 31 leaves it at 31, and a down step at 0 leaves it at 0.
- R5: `drv_code` holds its value in every cycle where `out_active` is 1. With the default build, while `out_active` is 0, `drv_code` takes the target one clock after the target changes.
- R6: When `out_active` falls from 1 to 0, any target change made while the pads were driven appears on `drv_code` at the next rising edge.
- R7: `settled` rises only on the edge that samples `out_active` at 0 after sampling it at 1 on the edge before. In addition, at least SETTLE_CYCLES (default 4096) edges must have passed since reset release. A transition made earlier does not set it.
- R8: Once set, `settled` stays at 1 until the next reset, whatever `out_active` does.
- R9: If `out_active` never goes from 1 to 0, `settled` stays 0 regardless of elapsed time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_up | input | 1 | Comparator result: 1 asks for a higher code, 0 for a lower code |
| out_active | input | 1 | 1 while the data pads are driven (Low-Z), 0 while they are High-Z |
| drv_code | output | CODE_W (5) | Strength code applied to the driver legs |
| settled | output | 1 | Sticky flag: power-up calibration is complete |

## Verification
The assertions check several properties on every cycle. The applied code never moves while the pads are driven. The target moves by at most one step, never more often than once per evaluation period, and never past either end. The settled flag is sticky, and it rises only after the power-up count and a driven-to-High-Z transition. The directed scenarios cover what needs known values. They show the exact edge on which each step lands, the direction of each step, the recovery from a saturated end, and the release of updates held back during a driven stretch. They also show that settled stays 0 both after an early transition and when no transition ever comes.

// File: rtl/drv_trim_pkg.sv
package drv_trim_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } trim_dir_e;

endpackage

// File: rtl/trim_tick_gen.sv
module trim_tick_gen #(
   parameter int PERIOD = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] phase;

   assign tick = (phase == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase <= '0;
      else if (tick) phase <= '0;
      else           phase <= phase + 1'b1;
   end
endmodule

// File: rtl/trim_code_step.sv
module trim_code_step
   import drv_trim_pkg::*;
#(
   parameter int CODE_W     = 5,
   parameter int RESET_CODE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  trim_dir_e         dir,
   output logic [CODE_W-1:0] code
);
   localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] INIT = CODE_W'(RESET_CODE);

   logic at_top;
   logic at_bot;

   assign at_top = (code == TOP);
   assign at_bot = (code == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= INIT;
      end else if (step_en) begin
         if (dir == DIR_UP && !at_top)        code <= code + 1'b1;
         else if (dir == DIR_DOWN && !at_bot) code <= code - 1'b1;
      end
   end
endmodule

// File: rtl/trim_settle_mon.sv
module trim_settle_mon #(
   parameter int SETTLE_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic out_active,
   output logic hiz_entry,
   output logic settled
);
   localparam int SW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [SW-1:0] LIMIT = SW'(SETTLE_CYCLES);

   logic [SW-1:0] age;
   logic          age_done;
   logic          active_q;

   assign age_done  = (age == LIMIT);
   assign hiz_entry = active_q & ~out_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age      <= '0;
         active_q <= 1'b0;
         settled  <= 1'b0;
      end else begin
         if (!age_done) age <= age + 1'b1;
         active_q <= out_active;
         if (age_done && hiz_entry) settled <= 1'b1;
      end
   end
endmodule

// File: rtl/drv_trim_ctrl.sv
module drv_trim_ctrl
   import drv_trim_pkg::*;
#(
   parameter int CODE_W        = 5,
   parameter int RESET_CODE    = 16,
   parameter int EVAL_PERIOD   = 64,
   parameter int SETTLE_CYCLES = 4096,
   parameter bit APPLY_ON_ENTRY_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_up,
   input  logic              out_active,
   output logic [CODE_W-1:0] drv_code,
   output logic              settled
);
   localparam logic [CODE_W-1:0] INIT = CODE_W'(RESET_CODE);

   if (CODE_W < 1 || CODE_W > 16) begin : g_bad_width
      $error("drv_trim_ctrl: CODE_W out of range");
   end
   if (RESET_CODE < 0 || RESET_CODE >= (1 << CODE_W)) begin : g_bad_reset
      $error("drv_trim_ctrl: RESET_CODE does not fit CODE_W");
   end
   if (EVAL_PERIOD < 2) begin : g_bad_period
      $error("drv_trim_ctrl: EVAL_PERIOD must be at least 2");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("drv_trim_ctrl: SETTLE_CYCLES must be positive");
   end

   logic              eval_tick;
   logic              hiz_entry;
   logic [CODE_W-1:0] tgt_code;
   trim_dir_e         dir;

   assign dir = cmp_up ? DIR_UP : DIR_DOWN;

   trim_tick_gen #(.PERIOD(EVAL_PERIOD)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (eval_tick)
   );

   trim_code_step #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_en(eval_tick),
      .dir    (dir),
      .code   (tgt_code)
   );

   trim_settle_mon #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_active(out_active),
      .hiz_entry (hiz_entry),
      .settled   (settled)
   );

   logic apply_now;

   if (APPLY_ON_ENTRY_ONLY) begin : g_apply_entry
      assign apply_now = hiz_entry;
   end else begin : g_apply_hiz
      assign apply_now = ~out_active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         drv_code <= INIT;
      else if (apply_now) drv_code <= tgt_code;
   end
endmodule

// File: rtl/drv_trim_ctrl_chk.sv
module drv_trim_ctrl_chk #(
   parameter int CODE_W        = 5,
   parameter int EVAL_PERIOD   = 64,
   parameter int SETTLE_CYCLES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_up,
   input logic              out_active,
   input logic [CODE_W-1:0] drv_code,
   input logic [CODE_W-1:0] tgt_code,
   input logic              settled
);
   localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

   logic [CODE_W-1:0] prev_tgt;
   logic [31:0]       gap;
   logic [31:0]       cyc;
   logic              tgt_moved;

   assign tgt_moved = (tgt_code != prev_tgt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_tgt <= tgt_code;
         gap      <= '0;
         cyc      <= '0;
      end else begin
         prev_tgt <= tgt_code;
         if (tgt_moved)          gap <= '0;
         else if (gap != '1)     gap <= gap + 1;
         if (cyc != '1)          cyc <= cyc + 1;
      end
   end

   // R5: driven pads freeze the applied code
   a_r5_hold_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
      out_active |=> $stable(drv_code));

   // R3: a single step per move
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_moved |-> ((int'(tgt_code) == int'(prev_tgt) + 1) ||
                     (int'(tgt_code) == int'(prev_tgt) - 1)));

   // R2: moves are spaced by a full evaluation period
   a_r2_rate_limit: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_moved |-> (gap >= 32'(EVAL_PERIOD - 1)));

   // R4: no wrap at the top or the bottom
   a_r4_top_sat: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tgt_code) == TOP && $past(cmp_up)) |-> (tgt_code == TOP));
   a_r4_bot_sat: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tgt_code) == '0 && !$past(cmp_up)) |-> (tgt_code == '0));

   // R8: settled is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      settled |=> settled);

   // R7: settled needs the power-up count and a driven-to-High-Z entry
   a_r7_wait_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> (cyc >= 32'(SETTLE_CYCLES)));
   a_r7_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> (!$past(out_active) && $past(out_active, 2)));
endmodule

bind drv_trim_ctrl drv_trim_ctrl_chk #(
   .CODE_W       (CODE_W),
   .EVAL_PERIOD  (EVAL_PERIOD),
   .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmp_up    (cmp_up),
   .out_active(out_active),
   .drv_code  (drv_code),
   .tgt_code  (tgt_code),
   .settled   (settled)
);

// File: tb/drv_trim_ctrl_test.sv
`timescale 1ns/1ps
module drv_trim_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_up = 1'b0;
   logic       out_active = 1'b0;
   logic [4:0] drv_code;
   logic       settled;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   drv_trim_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_up    (cmp_up),
      .out_active(out_active),
      .drv_code  (drv_code),
      .settled   (settled)
   );

   task automatic chk(input string tag, input int got, input int exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic act, input logic up);
      @(negedge clk);
      rst_n = 1'b0;
      out_active = act;
      cmp_up = up;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 code held in reset", drv_code, 16);
      chk("R1 settled low in reset", settled, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state;
      do_reset(1'b0, 1'b1);
      #1;
      chk("R1 code after release", drv_code, 16);
      chk("R1 settled after release", settled, 0);
   endtask

   task automatic t_step_up_timing;
      do_reset(1'b0, 1'b1);
      edges(63);
      chk("R2 no move before edge 64", drv_code, 16);
      edges(1);
      chk("R5 applied lags target by one clock", drv_code, 16);
      edges(1);
      chk("R3 one step up", drv_code, 17);
      edges(62);
      chk("R2 no move inside period", drv_code, 17);
      edges(2);
      chk("R2 second evaluation", drv_code, 18);
      edges(2 * 64);
      chk("R3 four steps up", drv_code, 20);
   endtask

   task automatic t_step_down;
      do_reset(1'b0, 1'b0);
      edges(3 * 64 + 1);
      chk("R3 three steps down", drv_code, 13);
   endtask

   task automatic t_direction_change;
      do_reset(1'b0, 1'b1);
      edges(3 * 64 + 1);
      chk("R3 up three", drv_code, 19);
      cmp_up = 1'b0;
      edges(64);
      chk("R3 then down one", drv_code, 18);
   endtask

   task automatic t_saturate;
      do_reset(1'b0, 1'b1);
      edges(20 * 64 + 1);
      chk("R4 top saturates at 31", drv_code, 31);
      cmp_up = 1'b0;
      edges(64);
      chk("R4 leaves top by one step", drv_code, 30);
      do_reset(1'b0, 1'b0);
      edges(20 * 64 + 1);
      chk("R4 bottom saturates at 0", drv_code, 0);
      cmp_up = 1'b1;
      edges(64);
      chk("R4 leaves bottom by one step", drv_code, 1);
   endtask

   task automatic t_hold_while_driven;
      do_reset(1'b1, 1'b1);
      edges(5 * 64 + 10);
      chk("R5 code frozen while driven", drv_code, 16);
      out_active = 1'b0;
      #1;
      chk("R6 not yet applied before edge", drv_code, 16);
      edges(1);
      chk("R6 pending update on High-Z entry", drv_code, 21);
      edges(1);
      chk("R7 early entry does not settle", settled, 0);
   endtask

   task automatic t_settle;
      do_reset(1'b1, 1'b1);
      edges(4100);
      chk("R9 count done but no entry", settled, 0);
      out_active = 1'b0;
      edges(1);
      chk("R7 settles on first entry after count", settled, 1);
      out_active = 1'b1;
      edges(5);
      out_active = 1'b0;
      edges(5);
      chk("R8 settled stays set", settled, 1);
      out_active = 1'b1;
      edges(3);
      chk("R8 settled stays set while driven", settled, 1);
      do_reset(1'b0, 1'b1);
      edges(4300);
      chk("R9 never driven never settles", settled, 0);
   endtask

   initial begin
      #1_000_000;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      t_reset_state();
      t_step_up_timing();
      t_step_down();
      t_direction_change();
      t_saturate();
      t_hold_while_driven();
      t_settle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule